// File: doc/BRIEF.md
# Timed-Unlock Nonvolatile Write Controller

This block guards writes to a small nonvolatile byte store. Software reaches it through three byte-wide registers on a simple write bus: an address register, a data register and a control register. A programming operation starts only through a two-step sequence. First, software sets an unlock bit. Then, while that bit is still open, it sets a start bit. The unlock bit closes itself after a short fixed window. A start request that arrives after the window has closed does nothing.

Each operation erases the addressed byte, writes it, or does both in one step. A cycle timer holds the busy state for the length of the selected operation; these lengths stand in for real millisecond programming times. Two further inputs matter. An external busy input, raised while program memory is being updated, blocks a new start. A global interrupt enable qualifies the ready interrupt. A combinational observation port lets the store contents be inspected.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: Writing 1 to control bit 1 while the unlock bit is clear sets it for exactly UNLOCK_WIN (default 4) cycles. It then clears itself. Writing 1 again while it is open does not extend it.
- R2: Writing 1 to control bit 0 (start) launches an operation only under three conditions: the unlock bit is set in that cycle, no operation is in progress, and `pm_busy_i` is low. If any condition fails, the request is ignored and the store is unchanged.
- R3: `busy_o` stays high for T_ATOMIC cycles (default 34) in mode 00. It stays high for T_SPLIT cycles (default 18) in mode 01 or 10. It then falls in the same cycle that the result appears in the store.
- R4: The mode is taken from control bits 5:4 of the start write. Mode 00 stores the data register value. Mode 01 sets the byte to 0xFF. Mode 10 stores the old byte ANDed with the data register.
- R5: Mode 11 is a no-op. The start request is accepted, but `busy_o` never rises and the store is unchanged.
- R6: While `busy_o` is high, control writes do not change the mode field (`mode_o`).
- R7: Reset clears the mode field to 00 only when idle. During an operation, reset keeps the mode field and the busy state, and the timer pauses. The operation completes after reset is released, and the result is not visible in the store before then.
- R8: `irq_o` is high exactly when all three hold: the ready-interrupt enable (control bit 2) is set, `gie_i` is high, and no operation is in progress.
- R9: The address and data registers are captured at launch. Bus writes to them while busy do not affect the operation in progress.
- R10: After reset, `mode_o` is 00, and `mpe_o`, `rie_o`, `busy_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_wdata_i | input | DATA_W | Register write data |
| gie_i | input | 1 | Global interrupt enable |
| pm_busy_i | input | 1 | Program memory update in progress |
| peek_addr_i | input | ADDR_W | Store observation address |
| peek_data_o | output | DATA_W | Store byte at peek_addr_i |
| mode_o | output | 2 | Mode field |
| rie_o | output | 1 | Ready-interrupt enable |
| mpe_o | output | 1 | Unlock bit |
| busy_o | output | 1 | Start bit readback, high while programming |
| irq_o | output | 1 | Ready interrupt request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the expiry of the unlock window and the arrival of a start request. The bench sends the start exactly on the last open cycle, where it must launch, and one cycle later, where it must be ignored with the store unchanged. The second pair is reset and an operation in progress. The bench asserts reset mid-operation and judges three things: busy and the mode are retained, the old byte is still in the store, and the new value appears only after reset is released.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;
  typedef enum logic [1:0] {
    PM_ATOMIC = 2'b00,
    PM_ERASE  = 2'b01,
    PM_WRITE  = 2'b10,
    PM_NOP    = 2'b11
  } pmode_e;

  localparam int unsigned CB_START  = 0;
  localparam int unsigned CB_UNLOCK = 1;
  localparam int unsigned CB_RDYIE  = 2;
  localparam int unsigned CB_MODE   = 4;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/nvm_unlock_win.sv
module nvm_unlock_win #(
  parameter int unsigned WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic open_o
);
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          open_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!open_q && arm_i) begin
      open_q <= 1'b1;
      cnt_q  <= CW'(WIN - 1);
    end else if (open_q) begin
      if (cnt_q == '0) open_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_wr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned T_ATOMIC = 34,
  parameter int unsigned T_SPLIT  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  pmode_e            mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              commit_o,
  output pmode_e            op_mode_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam int unsigned CW = $clog2(T_ATOMIC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          launch;
  logic [CW-1:0] dur_m1;

  assign launch = go_i && (mode_i != PM_NOP);
  assign dur_m1 = (mode_i == PM_ATOMIC) ? CW'(T_ATOMIC - 1) : CW'(T_SPLIT - 1);

  // reset freezes a running operation instead of aborting it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if (busy_q) busy_q <= 1'b1;
      else begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end
    end else if (launch) begin
      busy_q <= 1'b1;
      cnt_q  <= dur_m1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (launch) begin
      op_mode_o <= mode_i;
      op_addr_o <= addr_i;
      op_data_o <= data_i;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0) && rst_ni;
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  pmode_e            mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (mode_i)
      PM_ATOMIC: nxt = data_i;
      PM_ERASE:  nxt = '1;
      PM_WRITE:  nxt = mem[addr_i] & data_i;
      default:   nxt = mem[addr_i];
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= nxt;
  end

  assign peek_data_o = mem[peek_addr_i];
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_wr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned UNLOCK_WIN = 4,
  parameter int unsigned T_ATOMIC   = 34,
  parameter int unsigned T_SPLIT    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_sel_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              gie_i,
  input  logic              pm_busy_i,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic [1:0]        mode_o,
  output logic              rie_o,
  output logic              mpe_o,
  output logic              busy_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  pmode_e            mode_q;
  logic              rie_q;
  logic              ctrl_wr, arm, go, unlock_open, busy, commit;
  pmode_e            wr_mode, op_mode;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  assign ctrl_wr = bus_we_i && (bus_sel_i == SEL_CTRL);
  assign wr_mode = pmode_e'(bus_wdata_i[CB_MODE +: 2]);
  assign arm     = ctrl_wr && bus_wdata_i[CB_UNLOCK];
  assign go      = ctrl_wr && bus_wdata_i[CB_START] && unlock_open && !busy && !pm_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      rie_q  <= 1'b0;
      if (busy) mode_q <= mode_q;
      else      mode_q <= PM_ATOMIC;
    end else begin
      if (bus_we_i && bus_sel_i == SEL_ADDR) addr_q <= bus_wdata_i[ADDR_W-1:0];
      if (bus_we_i && bus_sel_i == SEL_DATA) data_q <= bus_wdata_i;
      if (ctrl_wr) begin
        rie_q <= bus_wdata_i[CB_RDYIE];
        if (!busy) mode_q <= wr_mode;
      end
    end
  end

  nvm_unlock_win #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .open_o (unlock_open)
  );

  nvm_prog_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ATOMIC(T_ATOMIC), .T_SPLIT(T_SPLIT)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .mode_i    (wr_mode),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .busy_o    (busy),
    .commit_o  (commit),
    .op_mode_o (op_mode),
    .op_addr_o (op_addr),
    .op_data_o (op_data)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i       (clk_i),
    .we_i        (commit),
    .mode_i      (op_mode),
    .addr_i      (op_addr),
    .data_i      (op_data),
    .peek_addr_i (peek_addr_i),
    .peek_data_o (peek_data_o)
  );

  assign mode_o = mode_q;
  assign rie_o  = rie_q;
  assign mpe_o  = unlock_open;
  assign busy_o = busy;
  assign irq_o  = rie_q && gie_i && !busy;
endmodule

// File: rtl/nvm_wr_ctrl_chk.sv
module nvm_wr_ctrl_chk #(
  parameter int unsigned WIN    = 4,
  parameter int unsigned T_FULL = 34
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mpe_o,
  input logic       busy_o,
  input logic       irq_o,
  input logic [1:0] mode_o,
  input logic       pm_busy_i
);
  int unsigned mpe_run, busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpe_run  <= 0;
      busy_run <= 0;
    end else begin
      mpe_run  <= mpe_o  ? mpe_run + 1  : 0;
      busy_run <= busy_o ? busy_run + 1 : 0;
    end
  end

  assert_unlock_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mpe_run <= WIN);

  assert_start_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(mpe_o) && !$past(pm_busy_i)));

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= T_FULL);

  assert_mode_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(mode_o));

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_o);
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_chk #(.WIN(UNLOCK_WIN), .T_FULL(T_ATOMIC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mpe_o     (mpe_o),
  .busy_o    (busy_o),
  .irq_o     (irq_o),
  .mode_o    (mode_o),
  .pm_busy_i (pm_busy_i)
);

// File: tb/nvm_wr_ctrl_tb_top.sv
module nvm_wr_ctrl_tb_top;
  localparam int T_ATOMIC = 34;
  localparam int T_SPLIT  = 18;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_sel_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic       gie_i = 1'b0;
  logic       pm_busy_i = 1'b0;
  logic [3:0] peek_addr_i = 4'd0;
  logic [7:0] peek_data_o;
  logic [1:0] mode_o;
  logic       rie_o, mpe_o, busy_o, irq_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic rie_b = 1'b0;

  always #2 clk_i = ~clk_i;

  nvm_wr_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
    .bus_wdata_i(bus_wdata_i), .gie_i(gie_i), .pm_busy_i(pm_busy_i),
    .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o), .mode_o(mode_o),
    .rie_o(rie_o), .mpe_o(mpe_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  // {mode, addr, data, expected byte}
  localparam logic [31:0] VEC [6] = '{
    32'h00_03_5A_5A, 32'h02_03_0F_0A, 32'h01_03_00_FF,
    32'h02_03_3C_3C, 32'h00_09_C3_C3, 32'h03_09_00_C3
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic bus_wr(logic [1:0] sel, logic [7:0] val);
    bus_we_i = 1'b1; bus_sel_i = sel; bus_wdata_i = val;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic unlock(logic [1:0] mode);
    bus_wr(2'd2, {2'b00, mode, 1'b0, rie_b, 2'b10});
  endtask

  task automatic start(logic [1:0] mode);
    bus_wr(2'd2, {2'b00, mode, 1'b0, rie_b, 2'b01});
  endtask

  task automatic prog(logic [1:0] mode, logic [3:0] a, logic [7:0] d, int gap);
    bus_wr(2'd0, {4'h0, a});
    bus_wr(2'd1, d);
    unlock(mode);
    repeat (gap) @(negedge clk_i);
    start(mode);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 200) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic peek(string req, logic [3:0] a, int exp);
    peek_addr_i = a;
    #1;
    chk(req, int'(peek_data_o), exp);
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 mode", int'(mode_o), 0);
    chk("R10 mpe", int'(mpe_o), 0);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 rie/irq", int'({rie_o, irq_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [1:0] m;
      int dur;
      m = VEC[i][25:24];
      dur = (m == 2'd0) ? T_ATOMIC : (m == 2'd3) ? 0 : T_SPLIT;
      prog(m, VEC[i][19:16], VEC[i][15:8], 0);
      busy_len(n);
      chk((m == 2'd3) ? "R5 busy length" : "R3 busy length", n, dur);
      peek((m == 2'd3) ? "R5 store" : "R4 store", VEC[i][19:16], int'(VEC[i][7:0]));
    end

    // R2 start without unlock
    bus_wr(2'd0, 8'h09);
    bus_wr(2'd1, 8'h11);
    start(2'd0);
    chk("R2 no unlock busy", int'(busy_o), 0);
    peek("R2 no unlock store", 4'h9, 'hC3);

    // R1 window length, then late start rejected
    unlock(2'd0);
    chk("R1 open", int'(mpe_o), 1);
    unlock(2'd0);
    repeat (2) @(negedge clk_i);
    chk("R1 still open no extend", int'(mpe_o), 1);
    @(negedge clk_i);
    chk("R1 closed", int'(mpe_o), 0);
    start(2'd0);
    chk("R2 late start busy", int'(busy_o), 0);
    peek("R2 late start store", 4'h9, 'hC3);

    // R1 start on last open cycle accepted
    prog(2'd0, 4'h9, 8'h22, 3);
    busy_len(n);
    chk("R1 last cycle start", n, T_ATOMIC);
    peek("R1 last cycle store", 4'h9, 'h22);

    // R2 blocked by program-memory busy
    pm_busy_i = 1'b1;
    prog(2'd0, 4'h9, 8'h44, 0);
    chk("R2 pm_busy busy", int'(busy_o), 0);
    pm_busy_i = 1'b0;
    peek("R2 pm_busy store", 4'h9, 'h22);

    // R6 mode lock, R9 operand capture
    prog(2'd0, 4'h7, 8'h5A, 0);
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd1, 8'h99);
    bus_wr(2'd2, 8'h10);
    chk("R6 mode locked", int'(mode_o), 0);
    busy_len(n);
    peek("R9 target", 4'h7, 'h5A);
    peek("R9 other", 4'h3, 'h3C);

    // R8 interrupt
    gie_i = 1'b1;
    bus_wr(2'd2, 8'h04);
    chk("R8 irq ready", int'(irq_o), 1);
    gie_i = 1'b0;
    #1 chk("R8 irq gie off", int'(irq_o), 0);
    gie_i = 1'b1;
    @(negedge clk_i);
    rie_b = 1'b1;
    prog(2'd2, 4'h7, 8'hFF, 0);
    chk("R8 irq busy", int'(irq_o), 0);
    busy_len(n);
    chk("R8 irq done", int'(irq_o), 1);
    rie_b = 1'b0;

    // R7 reset during operation
    prog(2'd0, 4'h5, 8'h3C, 0);
    busy_len(n);
    prog(2'd2, 4'h5, 8'hF0, 0);
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7 busy held", int'(busy_o), 1);
    chk("R7 mode held", int'(mode_o), 2);
    peek_addr_i = 4'h5;
    #1 chk("R7 not yet written", int'(peek_data_o), 'h3C);
    @(negedge clk_i);
    rst_ni = 1'b1;
    busy_len(n);
    chk("R7 completes", int'(n > 0), 1);
    peek("R7 result", 4'h5, 'h30);

    // R7 idle reset clears mode
    bus_wr(2'd2, 8'h10);
    chk("R7 mode set", int'(mode_o), 1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R7 idle reset mode", int'(mode_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule